// File: doc/BRIEF.md
# Serial Link Signal-Quality Monitor

This block watches a recovered serial stream of 8b/10b line code. The stream arrives one bit per clock, and a valid strobe marks each real bit. It looks for two signs that the data is not legal line code. The first is a run of equal bits that is longer than the code allows. The second is a stretch of time in which no comma sync pattern appears.

Time is split into fixed intervals of valid bit times by a free-running counter. At the end of each interval the block latches one errored/clean verdict and pulses `interval_done` for one cycle. A hysteresis state machine turns the verdicts into an active-low `fail_n` output. Software or a bypass control can use that output to decide whether the link carries valid data.

The state machine has two states. In ST_PASS, `fail_n` is high. In ST_FAIL, `fail_n` is low. Its transitions are:
- **trip**: ST_PASS to ST_FAIL, on an errored interval that meets the mode's threshold.
- **recover**: ST_FAIL to ST_PASS, on a clean interval that meets the mode's threshold.
- **hold**: stay in the current state on any other cycle.

The thresholds depend on the mode:
- **Single-interval mode** (`mode_sel` = 0): the threshold is one interval.
- **Multi-interval mode** (`mode_sel` = 1): the threshold is four consecutive intervals of the same kind.

The mode register inside the block takes the value of `mode_sel` only at an interval boundary.

Top module: `link_quality_monitor`

## Requirements
- R1: A valid bit that makes a run of equal bits (ones or zeros) longer than 5 marks a run-length error. The sixth equal bit and every further equal bit each mark one.
- R2: A run of exactly 5 equal bits is not an error.
- R3: A comma sighting is a 7-bit window of the most recent valid bits, oldest bit first, equal to 0000101 or to 1111010. No sighting is possible until 7 valid bits have been received since reset.
- R4: An interval's verdict is errored (`interval_err` = 1) if the interval held at least one run-length error, or if it held no comma sighting. Otherwise the verdict is clean (`interval_err` = 0).
- R5: An interval spans exactly 2^INTERVAL_BITS valid bits. Cycles with `bit_valid` low neither advance the interval nor change the run or window state. `interval_done` is a one-cycle pulse in the cycle after the interval's last valid bit, and `interval_err` carries that interval's verdict in the same cycle.
- R6: In single-interval mode, each boundary sets `fail_n` to the inverse of the verdict: low after an errored interval, high after a clean one.
- R7: In multi-interval mode, `fail_n` goes low only after 4 consecutive errored intervals. It returns high only after 4 consecutive clean intervals.
- R8: In multi-interval mode, an interval of the opposite kind restarts the consecutive count that is in progress.
- R9: After reset, `fail_n` = 1, `interval_done` = 0 and `interval_err` = 0, and the run and window trackers are empty.
- R10: The run count and the comma window carry across interval boundaries. A run or a comma is credited to the interval in which its deciding bit arrives.
- R11: A change of `mode_sel` takes effect at the next boundary. At that boundary the consecutive counts restart from zero before the new interval is counted.
- R12: `fail_n` changes only in the cycle after an `interval_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Recovered serial data bit |
| bit_valid | input | 1 | High when bit_in carries a bit |
| mode_sel | input | 1 | 0 = single-interval mode, 1 = multi-interval mode |
| fail_n | output | 1 | Active-low link fail indication |
| interval_done | output | 1 | One-cycle pulse at each interval boundary |
| interval_err | output | 1 | Verdict of the interval just closed |

## Verification
The hardest situations to reach are the ones where state crosses an interval boundary. Examples are a comma whose bits are split between two intervals, and a long run that starts at the end of one interval and finishes in the next. The bench reaches these by placing crafted bit patterns at fixed positions of a short interval. It also inserts periodic invalid cycles, so that boundaries fall at positions the bench can predict. Mode changes are made mid-interval, after a partial streak of errored intervals, so that the counter clear at the next boundary decides the outcome.

// File: rtl/lqm_pkg.sv
package lqm_pkg;

    typedef enum logic {
        MODE_SINGLE = 1'b0,
        MODE_MULTI  = 1'b1
    } lqm_mode_e;

    typedef enum logic {
        ST_PASS = 1'b0,
        ST_FAIL = 1'b1
    } lqm_state_e;

    localparam int COMMA_LEN = 7;
    localparam int COMMA_NUM = 2;

    // Oldest bit in the MSB; both running-disparity forms.
    localparam logic [COMMA_NUM-1:0][COMMA_LEN-1:0] COMMA_SET = {7'b1111010, 7'b0000101};

endpackage

// File: rtl/lqm_run_tracker.sv
module lqm_run_tracker #(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic run_err
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 2);
    localparam logic [RUN_W-1:0] LEN_SAT = RUN_W'(RUN_LIMIT + 1);
    localparam logic [RUN_W-1:0] LEN_LIM = RUN_W'(RUN_LIMIT);

    logic [RUN_W-1:0] len_q, len_d;
    logic             last_q;

    always_comb begin
        if (len_q == '0 || bit_in != last_q) begin
            len_d = RUN_W'(1);
        end else if (len_q == LEN_SAT) begin
            len_d = LEN_SAT;
        end else begin
            len_d = len_q + RUN_W'(1);
        end
        run_err = bit_valid && (len_d > LEN_LIM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            last_q <= 1'b0;
        end else if (bit_valid) begin
            len_q  <= len_d;
            last_q <= bit_in;
        end
    end

    // An error flag must leave the tracker holding an over-limit run.
    assert_run_over_limit_R1: assert property (@(posedge clk) disable iff (rst)
        run_err |=> (len_q > LEN_LIM));

    // A run of exactly the limit never flags.
    assert_limit_run_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && len_q == LEN_LIM - RUN_W'(1) && bit_in == last_q) |-> !run_err);

endmodule

// File: rtl/lqm_comma_detect.sv
module lqm_comma_detect
    import lqm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic bit_in,
    output logic comma_hit
);
    localparam int FILL_W = $clog2(COMMA_LEN);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(COMMA_LEN - 1);

    logic [COMMA_LEN-1:0] win_q, win_d;
    logic [FILL_W-1:0]    fill_q;
    logic [COMMA_NUM-1:0] match;

    assign win_d = {win_q[COMMA_LEN-2:0], bit_in};

    for (genvar p = 0; p < COMMA_NUM; p++) begin : g_pat
        assign match[p] = (win_d == COMMA_SET[p]);
    end

    assign comma_hit = bit_valid && (fill_q == FILL_MAX) && (|match);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_valid) begin
            win_q <= win_d;
            if (fill_q != FILL_MAX) begin
                fill_q <= fill_q + FILL_W'(1);
            end
        end
    end

    // No sighting before the window has been filled with real bits.
    assert_hit_after_fill_R3: assert property (@(posedge clk) disable iff (rst)
        comma_hit |-> (fill_q == FILL_MAX && bit_valid));

endmodule

// File: rtl/lqm_interval_timer.sv
module lqm_interval_timer #(
    parameter int INTERVAL_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic run_err,
    input  logic comma_hit,
    output logic interval_done,
    output logic interval_err
);
    logic [INTERVAL_BITS-1:0] cnt_q;
    logic                     run_acc_q;
    logic                     comma_acc_q;
    logic                     last_bit;

    assign last_bit = bit_valid && (cnt_q == {INTERVAL_BITS{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q         <= '0;
            run_acc_q     <= 1'b0;
            comma_acc_q   <= 1'b0;
            interval_done <= 1'b0;
            interval_err  <= 1'b0;
        end else begin
            interval_done <= last_bit;
            if (bit_valid) begin
                cnt_q <= cnt_q + INTERVAL_BITS'(1);
            end
            if (last_bit) begin
                interval_err <= run_acc_q | run_err | ~(comma_acc_q | comma_hit);
                run_acc_q    <= 1'b0;
                comma_acc_q  <= 1'b0;
            end else begin
                run_acc_q   <= run_acc_q | run_err;
                comma_acc_q <= comma_acc_q | comma_hit;
            end
        end
    end

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        interval_done |=> !interval_done);

    assert_done_after_valid_R5: assert property (@(posedge clk) disable iff (rst)
        interval_done |-> (cnt_q == '0));

    // A run error inside the interval forces an errored verdict.
    assert_run_forces_err_R4: assert property (@(posedge clk) disable iff (rst)
        (last_bit && run_err) |=> interval_err);

endmodule

// File: rtl/lqm_fail_fsm.sv
module lqm_fail_fsm
    import lqm_pkg::*;
#(
    parameter int HYST_COUNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic iv_done,
    input  logic iv_err,
    input  logic mode_sel,
    output logic fail_n
);
    localparam int HW = $clog2(HYST_COUNT) + 1;
    localparam logic [HW-1:0] CNT_MAX = '1;
    localparam logic [HW-1:0] HLIM    = HW'(HYST_COUNT);

    lqm_state_e       state_q, state_d;
    lqm_mode_e        mode_q, mode_d;
    logic [HW-1:0]    bad_q, good_q, bad_d, good_d;
    logic [HW-1:0]    bad_base, good_base, bad_inc, good_inc;
    logic             mode_changed, single_now;

    always_comb begin
        mode_d       = iv_done ? lqm_mode_e'(mode_sel) : mode_q;
        mode_changed = iv_done && (lqm_mode_e'(mode_sel) != mode_q);
        single_now   = (mode_d == MODE_SINGLE);
        bad_base     = mode_changed ? '0 : bad_q;
        good_base    = mode_changed ? '0 : good_q;
        bad_inc      = (bad_base == CNT_MAX) ? CNT_MAX : bad_base + HW'(1);
        good_inc     = (good_base == CNT_MAX) ? CNT_MAX : good_base + HW'(1);

        bad_d  = bad_q;
        good_d = good_q;
        if (iv_done) begin
            if (single_now) begin
                bad_d  = '0;
                good_d = '0;
            end else if (iv_err) begin
                bad_d  = bad_inc;
                good_d = '0;
            end else begin
                bad_d  = '0;
                good_d = good_inc;
            end
        end

        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (iv_done && iv_err && (single_now || bad_inc >= HLIM)) state_d = ST_FAIL;
            ST_FAIL: if (iv_done && !iv_err && (single_now || good_inc >= HLIM)) state_d = ST_PASS;
            default: state_d = ST_PASS;
        endcase
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PASS;
            mode_q  <= MODE_SINGLE;
            bad_q   <= '0;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            bad_q   <= bad_d;
            good_q  <= good_d;
        end
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            ST_PASS: fail_n = 1'b1;
            ST_FAIL: fail_n = 1'b0;
            default: fail_n = 1'b1;
        endcase
    end

    assert_single_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (iv_done && !mode_sel) |=> (fail_n == !$past(iv_err)));

    assert_multi_no_early_trip_R7: assert property (@(posedge clk) disable iff (rst)
        (iv_done && iv_err && mode_sel && mode_q == MODE_MULTI && bad_q < HLIM - HW'(2))
        |=> $stable(fail_n));

    assert_fail_moves_on_boundary_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(fail_n) |-> $past(iv_done));

    assert_mode_change_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (iv_done && mode_sel && mode_q == MODE_SINGLE) |=> (bad_q <= HW'(1) && good_q <= HW'(1)));

endmodule

// File: rtl/link_quality_monitor.sv
module link_quality_monitor #(
    parameter int INTERVAL_BITS = 15,
    parameter int RUN_LIMIT     = 5,
    parameter int HYST_COUNT    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic mode_sel,
    output logic fail_n,
    output logic interval_done,
    output logic interval_err
);
    logic run_err;
    logic comma_hit;

    lqm_run_tracker #(.RUN_LIMIT(RUN_LIMIT)) u_run (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .run_err   (run_err)
    );

    lqm_comma_detect u_comma (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .bit_in    (bit_in),
        .comma_hit (comma_hit)
    );

    lqm_interval_timer #(.INTERVAL_BITS(INTERVAL_BITS)) u_timer (
        .clk           (clk),
        .rst           (rst),
        .bit_valid     (bit_valid),
        .run_err       (run_err),
        .comma_hit     (comma_hit),
        .interval_done (interval_done),
        .interval_err  (interval_err)
    );

    lqm_fail_fsm #(.HYST_COUNT(HYST_COUNT)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .iv_done  (interval_done),
        .iv_err   (interval_err),
        .mode_sel (mode_sel),
        .fail_n   (fail_n)
    );

    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (fail_n && !interval_done && !interval_err));

endmodule

// File: tb/sim_link_quality_monitor.sv
module sim_link_quality_monitor;
    localparam int IVB    = 6;
    localparam int IV_LEN = 1 << IVB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0, bit_valid = 1'b0, mode_sel = 1'b0;
    logic fail_n, interval_done, interval_err;

    always #2.5 clk = ~clk;

    link_quality_monitor #(.INTERVAL_BITS(IVB)) u0 (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid), .mode_sel(mode_sel),
        .fail_n(fail_n), .interval_done(interval_done), .interval_err(interval_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // Reference model state
    int   rl_len = 0;
    logic rl_last = 0;
    logic [6:0] win = '0;
    int   nfill = 0, pos = 0;
    bit   run_seen = 0, comma_seen = 0;
    bit   exp_done_next = 0, exp_err = 0, fail_pend = 0;
    bit   exp_fail = 0, prev_err = 0;
    int   mm = 0, bc = 0, gc = 0;
    string err_tag, fail_tag;
    int   cyc = 0;

    int kinds[128];
    int modes[128];
    int n_iv = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic gen_bit(int kind, int idx);
        logic b;
        logic [6:0] p0;
        logic [6:0] p1;
        b  = idx[0];
        p0 = 7'b0000101;
        p1 = 7'b1111010;
        if ((kind == 0 || kind == 2 || kind == 3 || kind == 7 || kind == 8) && idx >= 10 && idx <= 16)
            b = p0[6 - (idx - 10)];
        if (kind == 2 && idx >= 30 && idx <= 35) b = 1'b1;
        if (kind == 3 && idx >= 32 && idx <= 35) b = 1'b1;
        if (kind == 4 && idx >= 60) b = 1'b0;
        if (kind == 5 && idx <= 2) b = (idx != 1);
        if (kind == 6 && idx >= 40 && idx <= 46) b = p1[6 - (idx - 40)];
        if (kind == 7 && idx >= 61) b = 1'b1;
        if (kind == 8 && idx <= 2) b = 1'b1;
        return b;
    endfunction

    function automatic string kind_tag(int k);
        case (k)
            1: return "R4";
            2: return "R1";
            3: return "R2";
            4: return "R4";
            5, 7, 8: return "R10";
            default: return "R3";
        endcase
    endfunction

    task automatic model_bit(logic b, int kind);
        if (rl_len == 0 || b != rl_last) rl_len = 1; else rl_len++;
        rl_last = b;
        if (rl_len > 5) run_seen = 1;
        win = {win[5:0], b};
        nfill++;
        if (nfill >= 7 && (win == 7'b0000101 || win == 7'b1111010)) comma_seen = 1;
        pos++;
        if (pos == IV_LEN) begin
            pos = 0;
            exp_done_next = 1;
            exp_err = run_seen || !comma_seen;
            err_tag = kind_tag(kind);
            run_seen = 0;
            comma_seen = 0;
        end
    endtask

    task automatic model_fsm(int m);
        bit changed;
        changed = (m != mm);
        if (changed) begin bc = 0; gc = 0; mm = m; end
        if (m == 0) begin
            exp_fail = exp_err;
            bc = 0; gc = 0;
            fail_tag = changed ? "R11" : "R6";
        end else begin
            if (exp_err) begin gc = 0; if (bc < 7) bc++; if (bc >= 4) exp_fail = 1; end
            else begin bc = 0; if (gc < 7) gc++; if (gc >= 4) exp_fail = 0; end
            fail_tag = changed ? "R11" : ((exp_err != prev_err) ? "R8" : "R7");
        end
        prev_err = exp_err;
    endtask

    task automatic step(logic v, logic b, int m, int kind);
        @(negedge clk);
        if (fail_pend) begin
            check(fail_n == !exp_fail, fail_tag, fail_n, !exp_fail);
            fail_pend = 0;
        end
        if (exp_done_next) begin
            check(interval_done == 1'b1, "R5", interval_done, 1);
            check(interval_err == exp_err, err_tag, interval_err, exp_err);
            check(fail_n == !exp_fail, "R12", fail_n, !exp_fail);
        end else if (interval_done) begin
            check(1'b0, "R5", interval_done, 0);
        end
        bit_valid = v;
        bit_in    = b;
        mode_sel  = m[0];
        if (exp_done_next) begin
            exp_done_next = 0;
            model_fsm(m);
            fail_pend = 1;
        end
        cyc++;
        if (v) model_bit(b, kind);
    endtask

    task automatic add_iv(int k, int m);
        kinds[n_iv] = k;
        modes[n_iv] = m;
        n_iv++;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        int prev_m;
        // Phase A: single-interval mode, pattern sweep
        add_iv(0,0); add_iv(1,0); add_iv(0,0); add_iv(2,0); add_iv(0,0); add_iv(3,0);
        add_iv(4,0); add_iv(5,0); add_iv(6,0); add_iv(7,0); add_iv(8,0); add_iv(0,0);
        // Phase B: multi-interval streak lengths 1..5
        for (int nb = 1; nb <= 5; nb++) begin
            for (int j = 0; j < nb; j++) add_iv(2,1);
            for (int j = 0; j < 5; j++) add_iv(0,1);
        end
        // Phase C: mode changes against partial streaks
        for (int j = 0; j < 3; j++) add_iv(1,1);
        add_iv(1,0);
        for (int j = 0; j < 4; j++) add_iv(0,1);
        add_iv(1,0); add_iv(1,0); add_iv(0,0);

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(fail_n == 1'b1, "R9", fail_n, 1);
        check(interval_done == 1'b0, "R9", interval_done, 0);
        check(interval_err == 1'b0, "R9", interval_err, 0);

        prev_m = 0;
        for (int iv = 0; iv < n_iv; iv++) begin
            for (int idx = 0; idx < IV_LEN; idx++) begin
                int m;
                m = (idx >= 20) ? modes[iv] : prev_m;
                while ((cyc % 7) == 3) step(1'b0, cyc[0], m, kinds[iv]);
                step(1'b1, gen_bit(kinds[iv], idx), m, kinds[iv]);
            end
            prev_m = modes[iv];
        end
        repeat (4) step(1'b0, 1'b0, prev_m, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule